// File: doc/BRIEF.md
# Clock Mode Controller with Guarded Divider

This block picks the CPU clock source and the divide ratio for a small microcontroller. Software programs it through a simple write port with address, data and enable. It keeps the mode control bits. Before any write is applied, the block checks it against the legal mode transitions and the ordering rules. An illegal write changes nothing and raises a sticky error flag. The block drives three outputs: a source select, the current divide ratio, and a CPU clock-enable pulse made by a counter that runs on the source clock. It also drives a flag that asks for two memory wait states. The oscillators are not part of the block. Each one appears only as a stable flag, and the main oscillator also has a stabilization-timer-done flag.

The register map has four addresses. Address 0 holds the mode byte: bit0 divide-by-8, bits 2:1 divider select, bit3 sub-clock select, bit4 on-chip-oscillator select, bit5 main-clock stop, bit6 sub-oscillator enable, bit7 high drive. Address 1 holds the guard byte: bit0 enables oscillation-stop detection. Address 2 holds the PLL byte: bit0 PLL enable, bit1 PLL select, bit2 two-wait. Address 3 is status: bit0 is the error flag (write 1 to clear) and bit1 shows that a source switch is pending. The source select output reads 0 for main, 1 for sub, 2 for the on-chip oscillator and 3 for the PLL.

A switch to the main or sub clock is recorded at once but only takes effect when the oscillator in question reports stable. Switches to the on-chip oscillator or the PLL take effect on the next cycle.

Top module: `clkmode_top`

## Requirements
- R1: After reset, the mode byte reads 0x81, the PLL byte reads 0x04, the source is main (0), the ratio is 8, the two-wait output is 1 and the error flag is 0.
- R2: On the main or on-chip path with divide-by-8 at 0, the divider select gives these ratios: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 16. With divide-by-8 at 1, the ratio is 8 whatever the select holds.
- R3: The clock-enable output is high for exactly one cycle in every N cycles, where N is the current ratio. At ratio 1 it is high on every cycle.
- R4: Selecting the sub clock is rejected unless the sub-oscillator enable is already 1 and stays 1. Once accepted, the source becomes sub (1) only after the sub-stable input is seen high, and the ratio on sub is 1.
- R5: Setting main-clock stop is rejected unless the CPU already runs from the sub clock or the on-chip oscillator and keeps doing so.
- R6: While the oscillation-stop-detect bit is 1, any write that would change the source, the stop bit or the divider is rejected.
- R7: A mode write that changes both the divider select and the divide-by-8 bit is rejected.
- R8: While the on-chip oscillator is deselected and the main clock is stopped, divide-by-8 and high drive read as 1. Writes to these two bits are then ignored without raising an error.
- R9: Leaving the on-chip oscillator for the main clock is rejected unless divide-by-8 is already 1.
- R10: PLL select is accepted only if the PLL enable is already 1 and the main clock runs undivided with divide-by-8 at 0. The source then becomes PLL (3) with ratio 1. While the PLL is selected, mode changes are rejected.
- R11: A write that changes the two-wait bit while the PLL is enabled is rejected. So is turning the PLL on with two-wait at 0.
- R12: A rejected write leaves every register bit unchanged and sets the error flag. The flag stays set until a write of 1 to status bit0.
- R13: After a switch to main is accepted, the source stays at its old value and status bit1 reads 1 until both main-stable and stabilization-done are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data for rdAddr (combinational) |
| mainStable | input | 1 | Main oscillator is stable |
| stabDone | input | 1 | Main stabilization timer has expired |
| subStable | input | 1 | Sub oscillator is stable |
| srcSel | output | 2 | Active source: 0 main, 1 sub, 2 on-chip, 3 PLL |
| divRatio | output | 5 | Active divide ratio (1, 2, 4, 8 or 16) |
| cpuClkEn | output | 1 | CPU clock-enable pulse |
| waitTwo | output | 1 | Two memory wait states requested |
| errFlag | output | 1 | Sticky rejected-write flag |

## Verification
The assertions check several properties on every cycle:
- the error flag stays set until a clear write;
- an active source changes to main or sub only when the matching stable inputs were high in the cycle before;
- the ratio is always a single power of two, and it is 1 on the sub and PLL paths;
- clock-enable pulses never come back to back at ratios above 1;
- the PLL never runs with one wait state.

The bench scenarios cover what needs a history of writes: the legality rules for each transition, the ordering between divider select and divide-by-8, the forced bits while the main clock is stopped, the pending switch states, and the pulse counts over a window.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_ROC  = 2'd2,
    SRC_PLL  = 2'd3
  } clkSrc_e;

  localparam int MAX_DIV = 16;
  localparam int RATIO_W = $clog2(MAX_DIV) + 1;

  localparam logic [1:0] ADR_MODE  = 2'd0;
  localparam logic [1:0] ADR_GUARD = 2'd1;
  localparam logic [1:0] ADR_PLL   = 2'd2;
  localparam logic [1:0] ADR_STAT  = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    clkSrc_e    target;
    logic       div8;
    logic [1:0] divSel;
  } modeStrobe_t;
endpackage

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter bit PLL_FAST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              pendingIn,
  output modeStrobe_t       strobe,
  output logic              waitTwo,
  output logic              errFlag
);
  logic div8, subSel, rocSel, mainStop, subEn, drvHigh, oscDet;
  logic pllEn, pllSel, twoWait, errQ;
  logic [1:0] divSel;

  logic nDiv8, nSub, nRoc, nStop, nSubEn, nDrv, forceNext, effDiv8, effDrv;
  logic [1:0] nDivSel;
  logic nPllEn, nPllSel, nTwo, highSpeed, modeChg, modeBad, pllBad;
  logic isMode, isGuard, isPll, isStat, reject;

  assign isMode  = wrEn && (wrAddr == ADDR_W'(ADR_MODE));
  assign isGuard = wrEn && (wrAddr == ADDR_W'(ADR_GUARD));
  assign isPll   = wrEn && (wrAddr == ADDR_W'(ADR_PLL));
  assign isStat  = wrEn && (wrAddr == ADDR_W'(ADR_STAT));

  always_comb begin
    nDiv8     = wrData[0];
    nDivSel   = wrData[2:1];
    nSub      = wrData[3];
    nRoc      = wrData[4];
    nStop     = wrData[5];
    nSubEn    = wrData[6];
    nDrv      = wrData[7];
    forceNext = !nRoc && nStop;
    effDiv8   = forceNext | nDiv8;
    effDrv    = forceNext | nDrv;
    modeChg   = (effDiv8 != div8) || (nDivSel != divSel) || (nSub != subSel) ||
                (nRoc != rocSel) || (nStop != mainStop);
    modeBad   = (oscDet && modeChg) ||
                ((effDiv8 != div8) && (nDivSel != divSel)) ||
                (nStop && (!(nSub || nRoc) || (!mainStop && !(subSel || rocSel)))) ||
                (nSub && !(subEn && nSubEn)) ||
                (rocSel && !nRoc && !nSub && !div8) ||
                (pllSel && modeChg);

    nPllEn    = wrData[0];
    nPllSel   = wrData[1];
    nTwo      = wrData[2];
    highSpeed = !subSel && !rocSel && !mainStop && !div8 && (divSel == 2'b00);
    pllBad    = (pllEn && (nTwo != twoWait)) ||
                (PLL_FAST && nPllEn && !pllEn && !nTwo) ||
                (nPllSel && !nPllEn) ||
                (nPllSel && !pllSel && !(pllEn && highSpeed)) ||
                (oscDet && (nPllSel != pllSel));
    reject    = (isMode && modeBad) || (isPll && pllBad);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      div8 <= 1'b1;  divSel <= 2'b00; subSel <= 1'b0; rocSel <= 1'b0;
      mainStop <= 1'b0; subEn <= 1'b0; drvHigh <= 1'b1; oscDet <= 1'b0;
      pllEn <= 1'b0; pllSel <= 1'b0; twoWait <= 1'b1; errQ <= 1'b0;
    end else begin
      if (isMode && !modeBad) begin
        div8 <= effDiv8; divSel <= nDivSel; subSel <= nSub; rocSel <= nRoc;
        mainStop <= nStop; subEn <= nSubEn; drvHigh <= effDrv;
      end
      if (isGuard) oscDet <= wrData[0];
      if (isPll && !pllBad) begin
        pllEn <= nPllEn; pllSel <= nPllSel; twoWait <= nTwo;
      end
      if (reject) errQ <= 1'b1;
      else if (isStat && wrData[0]) errQ <= 1'b0;
    end
  end

  always_comb begin
    if (subSel)      strobe.target = SRC_SUB;
    else if (rocSel) strobe.target = SRC_ROC;
    else if (pllSel) strobe.target = SRC_PLL;
    else             strobe.target = SRC_MAIN;
    strobe.div8   = div8;
    strobe.divSel = divSel;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(ADR_MODE):  rdData[7:0] = {drvHigh, subEn, mainStop, rocSel, subSel, divSel, div8};
      ADDR_W'(ADR_GUARD): rdData[0]   = oscDet;
      ADDR_W'(ADR_PLL):   rdData[2:0] = {twoWait, pllSel, pllEn};
      default:            rdData[1:0] = {pendingIn, errQ};
    endcase
  end

  assign waitTwo = twoWait;
  assign errFlag = errQ;
endmodule

// File: rtl/clkmode_datapath.sv
module clkmode_datapath
  import clkmode_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  modeStrobe_t        strobe,
  input  logic               mainStable,
  input  logic               stabDone,
  input  logic               subStable,
  output clkSrc_e            activeSrc,
  output logic [RATIO_W-1:0] divRatio,
  output logic               cpuClkEn,
  output logic               pending
);
  logic [RATIO_W-1:0] cnt, cntNext;
  logic srcReady;

  always_comb begin
    case (strobe.target)
      SRC_MAIN: srcReady = mainStable && stabDone;
      SRC_SUB:  srcReady = subStable;
      default:  srcReady = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         activeSrc <= SRC_MAIN;
    else if (srcReady) activeSrc <= strobe.target;
  end

  assign pending = (activeSrc != strobe.target);

  always_comb begin
    if (activeSrc == SRC_SUB || activeSrc == SRC_PLL) divRatio = RATIO_W'(1);
    else if (strobe.div8)                              divRatio = RATIO_W'(8);
    else if (strobe.divSel == 2'b11)                   divRatio = RATIO_W'(MAX_DIV);
    else divRatio = RATIO_W'(1) << strobe.divSel;
  end

  assign cntNext  = cnt + 1'b1;
  assign cpuClkEn = (cntNext >= divRatio);

  always_ff @(posedge clk) begin
    if (!rstN || cpuClkEn) cnt <= '0;
    else                   cnt <= cntNext;
  end
endmodule

// File: rtl/clkmode_top.sv
module clkmode_top
  import clkmode_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter bit PLL_FAST = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic               mainStable,
  input  logic               stabDone,
  input  logic               subStable,
  output logic [1:0]         srcSel,
  output logic [RATIO_W-1:0] divRatio,
  output logic               cpuClkEn,
  output logic               waitTwo,
  output logic               errFlag
);
  modeStrobe_t strobe;
  clkSrc_e     activeSrc;
  logic        pending;

  clkmode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLL_FAST(PLL_FAST)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pendingIn(pending), .strobe(strobe),
    .waitTwo(waitTwo), .errFlag(errFlag)
  );

  clkmode_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mainStable(mainStable),
    .stabDone(stabDone), .subStable(subStable), .activeSrc(activeSrc),
    .divRatio(divRatio), .cpuClkEn(cpuClkEn), .pending(pending)
  );

  assign srcSel = activeSrc;
endmodule

// File: rtl/clkmode_chk.sv
module clkmode_chk
  import clkmode_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter bit PLL_FAST = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic               mainStable,
  input logic               stabDone,
  input logic               subStable,
  input logic [1:0]         srcSel,
  input logic [RATIO_W-1:0] divRatio,
  input logic               cpuClkEn,
  input logic               waitTwo,
  input logic               errFlag
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !(wrEn && wrAddr == ADDR_W'(ADR_STAT) && wrData[0]) |=> errFlag); // R12
  AST_SUB_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(srcSel) && srcSel == SRC_SUB) |-> $past(subStable)); // R4
  AST_MAIN_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(srcSel) && srcSel == SRC_MAIN) |-> $past(mainStable && stabDone)); // R13
  AST_SUB_UNDIVIDED: assert property (@(posedge clk) disable iff (!rstN)
    srcSel == SRC_SUB |-> divRatio == RATIO_W'(1)); // R4
  AST_PLL_UNDIVIDED: assert property (@(posedge clk) disable iff (!rstN)
    srcSel == SRC_PLL |-> divRatio == RATIO_W'(1)); // R10
  AST_RATIO_POW2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(divRatio) == 1); // R2
  AST_EN_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && divRatio != RATIO_W'(1)) |=> (!cpuClkEn || !$stable(divRatio))); // R3
  AST_PLL_TWO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (PLL_FAST && srcSel == SRC_PLL) |-> waitTwo); // R11
endmodule

bind clkmode_top clkmode_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLL_FAST(PLL_FAST)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .mainStable(mainStable), .stabDone(stabDone), .subStable(subStable),
  .srcSel(srcSel), .divRatio(divRatio), .cpuClkEn(cpuClkEn),
  .waitTwo(waitTwo), .errFlag(errFlag)
);

// File: tb/test_clkmode_top.sv
module test_clkmode_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic mainStable = 1'b1, stabDone = 1'b1, subStable = 1'b0;
  logic [1:0] srcSel;
  logic [4:0] divRatio;
  logic cpuClkEn, waitTwo, errFlag;
  int nChecks = 0, nErr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkmode_top i_clkmode_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .mainStable(mainStable), .stabDone(stabDone),
    .subStable(subStable), .srcSel(srcSel), .divRatio(divRatio), .cpuClkEn(cpuClkEn),
    .waitTwo(waitTwo), .errFlag(errFlag)
  );

  // {addr, data, expErr, expRatio, expSrc}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'h81, 1'b0, 5'd8,  2'd0},
    {2'd0, 8'h83, 1'b0, 5'd8,  2'd0},
    {2'd0, 8'h82, 1'b0, 5'd2,  2'd0},
    {2'd0, 8'h84, 1'b0, 5'd4,  2'd0},
    {2'd0, 8'h86, 1'b0, 5'd16, 2'd0},
    {2'd0, 8'h80, 1'b0, 5'd1,  2'd0},
    {2'd0, 8'h83, 1'b1, 5'd1,  2'd0},
    {2'd0, 8'h81, 1'b0, 5'd8,  2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic clrErr();
    wr(2'd3, 8'h01);
  endtask

  task automatic countEn(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (cpuClkEn) n++;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); check("R1 mode byte", d, 8'h81);
    rd(2'd2, d); check("R1 pll byte", d, 8'h04);
    check("R1 src", srcSel, 0);
    check("R1 ratio", divRatio, 8);
    check("R1 waitTwo", waitTwo, 1);
    check("R1 err", errFlag, 0);

    // R2 / R7 divider table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      check("R2 R7 table err", errFlag, VEC[i][7]);
      check("R2 table ratio", divRatio, VEC[i][6:2]);
      check("R2 table src", srcSel, VEC[i][1:0]);
      clrErr();
    end

    // R3 enable pulse spacing
    countEn(64, n); check("R3 pulses ratio8", n, 8);
    wr(2'd0, 8'h80); countEn(64, n); check("R3 pulses ratio1", n, 64);
    wr(2'd0, 8'h82); countEn(64, n); check("R3 pulses ratio2", n, 32);
    wr(2'd0, 8'h86); countEn(64, n); check("R3 pulses ratio16", n, 4);
    wr(2'd0, 8'h80); wr(2'd0, 8'h81);
    check("R3 back to 8", divRatio, 8);

    // R6 guard blocks mode changes; R12 state unchanged and flag sticky
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h80);
    check("R6 reject under guard", errFlag, 1);
    check("R6 ratio kept", divRatio, 8);
    rd(2'd0, d); check("R12 mode unchanged", d, 8'h81);
    wr(2'd3, 8'h00); check("R12 zero write keeps flag", errFlag, 1);
    wr(2'd3, 8'h01); check("R12 clear", errFlag, 0);
    wr(2'd1, 8'h00);

    // R5 stop illegal on main
    wr(2'd0, 8'hA1); check("R5 stop on main rejected", errFlag, 1); clrErr();

    // R4 sub selection
    wr(2'd0, 8'h89); check("R4 sub without enable", errFlag, 1); clrErr();
    wr(2'd0, 8'hC1); check("R4 enable sub osc", errFlag, 0);
    wr(2'd0, 8'hC9); check("R4 sub accepted", errFlag, 0);
    check("R4 pending src", srcSel, 0);
    rd(2'd3, d); check("R4 pending bit", d[1], 1);
    subStable = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R4 src sub", srcSel, 1);
    check("R4 ratio sub", divRatio, 1);

    // R5 stop legal on sub; R8 forced bits
    wr(2'd0, 8'hE9); check("R5 stop on sub ok", errFlag, 0);
    wr(2'd0, 8'h68); check("R8 no error", errFlag, 0);
    rd(2'd0, d); check("R8 forced bits read 1", d, 8'hE9);
    wr(2'd0, 8'hC9); check("R5 restart main", errFlag, 0);

    // R9 on-chip oscillator return
    wr(2'd0, 8'hD1); check("R9 src roc", srcSel, 2); check("R9 roc ratio8", divRatio, 8);
    wr(2'd0, 8'hD0); check("R2 roc ratio1", divRatio, 1);
    wr(2'd0, 8'hC0); check("R9 return without div8", errFlag, 1); check("R9 src kept", srcSel, 2);
    clrErr();
    wr(2'd0, 8'hD1);
    wr(2'd0, 8'hC1); check("R9 return ok", errFlag, 0);
    @(negedge clk);
    check("R9 src main", srcSel, 0);

    // R13 pending main switch
    stabDone = 1'b0;
    wr(2'd0, 8'hD1);
    wr(2'd0, 8'hC1);
    repeat (3) @(negedge clk);
    check("R13 src held", srcSel, 2);
    rd(2'd3, d); check("R13 pending bit", d[1], 1);
    stabDone = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R13 src main", srcSel, 0);
    rd(2'd3, d); check("R13 pending clear", d[1], 0);

    // R10 PLL entry
    wr(2'd2, 8'h07); check("R10 select with enable same write", errFlag, 1); clrErr();
    wr(2'd0, 8'hC0); check("R10 high speed", divRatio, 1);
    wr(2'd2, 8'h05); check("R10 pll enable", errFlag, 0);
    wr(2'd2, 8'h07); @(negedge clk);
    check("R10 src pll", srcSel, 3); check("R10 pll ratio", divRatio, 1);
    wr(2'd0, 8'hC1); check("R10 mode change under pll", errFlag, 1); clrErr();
    // R11 wait bit
    wr(2'd2, 8'h03); check("R11 wait change while on", errFlag, 1);
    check("R11 wait kept", waitTwo, 1); clrErr();
    wr(2'd2, 8'h05); @(negedge clk); check("R10 back to main", srcSel, 0);
    wr(2'd2, 8'h04); wr(2'd2, 8'h00);
    check("R11 wait written off", waitTwo, 0); check("R11 no err", errFlag, 0);
    wr(2'd2, 8'h01); check("R11 one wait enable rejected", errFlag, 1);
    rd(2'd2, d); check("R12 pll byte unchanged", d, 8'h00);

    done = 1;
    summary();
  end
endmodule